// File: doc/BRIEF.md
# Two-Wire Clocked Serial Target Transceiver

This block is the target end of a two-wire synchronous link whose clock is owned entirely by a remote host. The data wire is shared by both sides and is pulled low whenever nobody drives it. The block samples both wires with its own faster system clock and finds the host's clock edges in that sampled stream. It then moves one byte per transfer, in either direction, under the control of local logic.

Local logic starts a send by presenting a byte with a one-cycle `tx_start` strobe, or starts a receive with a one-cycle `rx_req` strobe. Every transfer has the same outer shape:

- A readiness handshake: on one host rising edge the target drives a one, and on the next it drives a zero and then lets go of the wire.
- Eight data bits.
- A postamble: the target waits for one more rising edge, drives a zero briefly and then releases the wire.

Driving zero before each release speeds up the slow fall of the pull-down. `busy` covers the whole transfer.

The controller is an enumerated state machine with these states:

- `ST_IDLE`: waits for a strobe. `tx_start` has priority, and either strobe moves to `ST_HS_WAIT`.
- `ST_HS_WAIT`: a rise leads to `ST_HS_ONE`, which drives 1.
- `ST_HS_ONE`: a rise leads to `ST_HS_ZERO`, which drives 0.
- `ST_HS_ZERO`: after `ZERO_CYC` system cycles it releases the wire and goes to `ST_TX_BIT` or `ST_RX_RISE`.
- `ST_TX_BIT`: each rise drives the next bit. After the eighth it goes to `ST_POST_WAIT`.
- `ST_RX_RISE`: a rise leads to `ST_RX_FALL`.
- `ST_RX_FALL`: each fall captures a bit and returns to `ST_RX_RISE`. After the eighth capture it goes to `ST_POST_WAIT`.
- `ST_POST_WAIT`: a rise drives 0 and leads to `ST_POST_ZERO`.
- `ST_POST_ZERO`: after `ZERO_CYC` cycles it releases the wire and returns to `ST_IDLE`.

Top module: `sertgt_port`

## Requirements
- R1: After reset `busy`, `sda_oe` and `rx_valid` are 0.
- R2: A `tx_start` or `rx_req` strobe in idle sets `busy` on the next cycle. When both strobes arrive in the same cycle, the send is taken.
- R3: On the first host rising edge after a start the target drives the data wire to 1 (`sda_oe`=1, `sda_o`=1) until the next rising edge.
- R4: On the second rising edge the target drives 0 for `ZERO_CYC` system cycles and then releases the wire (`sda_oe`=0), well before that clock high phase ends.
- R5: On a send, `sda_oe` stays 0 until the first data rising edge. Each of the eight data rising edges then drives one bit, bit 0 first, moving toward bit 7. Each bit is valid before the host's next falling edge.
- R6: On a send, the last bit stays on the wire until the postamble rising edge. The target then drives 0 and releases the wire.
- R7: On a receive, the wire is sampled at each of eight host falling edges, and the first sample becomes bit 0. `rx_valid` pulses for exactly one cycle, with the full byte on `rx_byte`, after the eighth falling edge. The target never drives the wire during the receive data bits.
- R8: On a receive, the postamble rising edge after the last bit makes the target drive 0 briefly and then release the wire.
- R9: `busy` returns to 0 only after the postamble release. While `busy` is 0 the wire is never driven.
- R10: A `tx_start` or `rx_req` strobe that arrives while `busy` is 1 has no effect on the bits sent, and no transfer follows it.
- R11: Every release of the wire is immediately preceded by driving 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the host clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Host serial clock, asynchronous |
| sda_i | input | 1 | Data wire as seen at the pad |
| sda_o | output | 1 | Value driven onto the data wire |
| sda_oe | output | 1 | Drive enable for the data wire |
| tx_byte | input | BITS | Byte to send, taken with `tx_start` |
| tx_start | input | 1 | One-cycle send request |
| rx_req | input | 1 | One-cycle receive request |
| rx_byte | output | BITS | Last received byte |
| rx_valid | output | 1 | One-cycle strobe marking a new `rx_byte` |
| busy | output | 1 | A transfer is in progress |

## Verification
Sends and receives run in a seeded random mix of directions and byte values, so bit order and sampling phase are tried with many different data patterns. Directed corner cases cover these situations:

- Bytes of all zeros and all ones. These separate a genuinely driven 1 from the pulled-down idle level.
- Simultaneous start and receive strobes, which shows the send priority.
- Strobes injected in the middle of a transfer. These must neither change the bits on the wire nor cause a later transfer.

The handshake and postamble are observed through the modelled wire, including the presence of a driven zero before each release.

// File: rtl/sertgt_pkg.sv
package sertgt_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HS_WAIT,
        ST_HS_ONE,
        ST_HS_ZERO,
        ST_TX_BIT,
        ST_RX_RISE,
        ST_RX_FALL,
        ST_POST_WAIT,
        ST_POST_ZERO
    } tgt_state_e;

    typedef enum logic {
        DIR_RX = 1'b0,
        DIR_TX = 1'b1
    } xfer_dir_e;

endpackage

// File: rtl/sertgt_sync.sv
module sertgt_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_bit
            logic [STAGES-1:0] pipe;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pipe <= '0;
                end else begin
                    pipe <= {pipe[STAGES-2:0], d[i]};
                end
            end
            assign q[i] = pipe[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/sertgt_edge.sv
module sertgt_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise,
    output logic fall
);

    logic prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev <= 1'b0;
        end else begin
            prev <= level;
        end
    end

    assign rise = level & ~prev;
    assign fall = ~level & prev;

endmodule

// File: rtl/sertgt_rxshift.sv
module sertgt_rxshift #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            shift_en,
    input  logic            ser_in,
    output logic [BITS-1:0] word
);

    // New bits enter at the top so the first one ends up in bit 0.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word <= '0;
        end else if (clear) begin
            word <= '0;
        end else if (shift_en) begin
            word <= {ser_in, word[BITS-1:1]};
        end
    end

endmodule

// File: rtl/sertgt_fsm.sv
module sertgt_fsm
    import sertgt_pkg::*;
#(
    parameter int BITS     = 8,
    parameter int ZERO_CYC = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sck_rise,
    input  logic            sck_fall,
    input  logic [BITS-1:0] tx_byte,
    input  logic            tx_start,
    input  logic            rx_req,
    output logic            rx_clear,
    output logic            rx_shift,
    output logic            rx_valid,
    output logic            sda_o,
    output logic            sda_oe,
    output logic            busy
);

    localparam int BCW = $clog2(BITS + 1);
    localparam int ZCW = $clog2(ZERO_CYC + 1);
    localparam logic [BCW-1:0] BIT_LAST  = BCW'(BITS - 1);
    localparam logic [ZCW-1:0] ZERO_LAST = ZCW'(ZERO_CYC - 1);

    tgt_state_e      state, state_n;
    xfer_dir_e       dir;
    logic [BCW-1:0]  bit_cnt;
    logic [ZCW-1:0]  zero_cnt;
    logic [BITS-1:0] tx_hold;

    logic acc_tx, acc_rx, bit_last, zero_last, in_zero;

    assign acc_tx    = (state == ST_IDLE) && tx_start;
    assign acc_rx    = (state == ST_IDLE) && !tx_start && rx_req;
    assign bit_last  = (bit_cnt == BIT_LAST);
    assign zero_last = (zero_cnt == ZERO_LAST);
    assign in_zero   = (state == ST_HS_ZERO) || (state == ST_POST_ZERO);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_n;
        end
    end

    // Next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:      if (acc_tx || acc_rx) state_n = ST_HS_WAIT;
            ST_HS_WAIT:   if (sck_rise) state_n = ST_HS_ONE;
            ST_HS_ONE:    if (sck_rise) state_n = ST_HS_ZERO;
            ST_HS_ZERO:   if (zero_last) state_n = (dir == DIR_TX) ? ST_TX_BIT : ST_RX_RISE;
            ST_TX_BIT:    if (sck_rise && bit_last) state_n = ST_POST_WAIT;
            ST_RX_RISE:   if (sck_rise) state_n = ST_RX_FALL;
            ST_RX_FALL:   if (sck_fall) state_n = bit_last ? ST_POST_WAIT : ST_RX_RISE;
            ST_POST_WAIT: if (sck_rise) state_n = ST_POST_ZERO;
            ST_POST_ZERO: if (zero_last) state_n = ST_IDLE;
            default:      state_n = ST_IDLE;
        endcase
    end

    // Direction, bit counter, zero-drive timer and send shifter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir      <= DIR_RX;
            bit_cnt  <= '0;
            zero_cnt <= '0;
            tx_hold  <= '0;
        end else begin
            if (acc_tx) begin
                dir     <= DIR_TX;
                tx_hold <= tx_byte;
            end else if (acc_rx) begin
                dir <= DIR_RX;
            end

            if (state == ST_HS_ZERO) begin
                bit_cnt <= '0;
            end else if ((state == ST_TX_BIT && sck_rise) ||
                         (state == ST_RX_FALL && sck_fall)) begin
                bit_cnt <= bit_cnt + 1'b1;
            end

            if (in_zero && !zero_last) begin
                zero_cnt <= zero_cnt + 1'b1;
            end else begin
                zero_cnt <= '0;
            end

            if (state == ST_TX_BIT && sck_rise) begin
                tx_hold <= tx_hold >> 1;
            end
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_o    <= 1'b0;
            sda_oe   <= 1'b0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            unique case (state)
                ST_HS_WAIT: if (sck_rise) begin
                    sda_oe <= 1'b1;
                    sda_o  <= 1'b1;
                end
                ST_HS_ONE: if (sck_rise) begin
                    sda_o <= 1'b0;
                end
                ST_HS_ZERO: if (zero_last) begin
                    sda_oe <= 1'b0;
                end
                ST_TX_BIT: if (sck_rise) begin
                    sda_oe <= 1'b1;
                    sda_o  <= tx_hold[0];
                end
                ST_RX_FALL: if (sck_fall && bit_last) begin
                    rx_valid <= 1'b1;
                end
                ST_POST_WAIT: if (sck_rise) begin
                    sda_oe <= 1'b1;
                    sda_o  <= 1'b0;
                end
                ST_POST_ZERO: if (zero_last) begin
                    sda_oe <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    assign busy     = (state != ST_IDLE);
    assign rx_clear = acc_rx;
    assign rx_shift = (state == ST_RX_FALL) && sck_fall;

endmodule

// File: rtl/sertgt_port.sv
module sertgt_port #(
    parameter int BITS     = 8,
    parameter int ZERO_CYC = 2,
    parameter int STAGES   = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sck_i,
    input  logic            sda_i,
    output logic            sda_o,
    output logic            sda_oe,
    input  logic [BITS-1:0] tx_byte,
    input  logic            tx_start,
    input  logic            rx_req,
    output logic [BITS-1:0] rx_byte,
    output logic            rx_valid,
    output logic            busy
);

    logic [1:0] sync_q;
    logic       sck_s, sda_s, sck_rise, sck_fall, rx_clear, rx_shift;

    sertgt_sync #(.WIDTH(2), .STAGES(STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sda_i, sck_i}),
        .q     (sync_q)
    );

    assign sck_s = sync_q[0];
    assign sda_s = sync_q[1];

    sertgt_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (sck_s),
        .rise  (sck_rise),
        .fall  (sck_fall)
    );

    sertgt_rxshift #(.BITS(BITS)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (rx_clear),
        .shift_en (rx_shift),
        .ser_in   (sda_s),
        .word     (rx_byte)
    );

    sertgt_fsm #(.BITS(BITS), .ZERO_CYC(ZERO_CYC)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .tx_byte  (tx_byte),
        .tx_start (tx_start),
        .rx_req   (rx_req),
        .rx_clear (rx_clear),
        .rx_shift (rx_shift),
        .rx_valid (rx_valid),
        .sda_o    (sda_o),
        .sda_oe   (sda_oe),
        .busy     (busy)
    );

endmodule

// File: rtl/sertgt_port_chk.sv
module sertgt_port_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic sda_o,
    input logic sda_oe,
    input logic rx_valid,
    input logic sck_rise
);

    // R9
    idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sda_oe);

    // R7
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R7
    valid_in_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> busy);

    // R11
    zero_before_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe) |-> !$past(sda_o));

    // R5
    drive_after_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> $past(sck_rise));

endmodule

bind sertgt_port sertgt_port_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .sda_o    (sda_o),
    .sda_oe   (sda_oe),
    .rx_valid (rx_valid),
    .sck_rise (sck_rise)
);

// File: tb/sertgt_port_tb.sv
`timescale 1ns/1ps
module sertgt_port_tb;

    localparam int BITS = 8;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0;
    logic host_en = 1'b0;
    logic host_val = 1'b0;
    logic [BITS-1:0] tx_byte = '0;
    logic tx_start = 1'b0;
    logic rx_req = 1'b0;
    logic sda_o, sda_oe, rx_valid, busy, line;
    logic [BITS-1:0] rx_byte;

    int n_chk = 0;
    int n_fail = 0;
    int valid_cnt = 0;
    logic [BITS-1:0] last_rx = '0;
    bit zero_seen = 1'b0;

    always #5 clk = ~clk;

    // Wire with pull-down
    assign line = sda_oe ? sda_o : (host_en ? host_val : 1'b0);

    sertgt_port #(.BITS(BITS)) u_dut (
        .clk(clk), .rst_n(rst_n), .sck_i(sck), .sda_i(line),
        .sda_o(sda_o), .sda_oe(sda_oe), .tx_byte(tx_byte),
        .tx_start(tx_start), .rx_req(rx_req), .rx_byte(rx_byte),
        .rx_valid(rx_valid), .busy(busy)
    );

    always @(negedge clk) begin
        if (sda_oe && !sda_o) zero_seen <= 1'b1;
        if (rx_valid) begin
            valid_cnt <= valid_cnt + 1;
            last_rx   <= rx_byte;
        end
    end

    function automatic logic exp_bit(input logic [BITS-1:0] b, input int k);
        return b[k];
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic host_edge(input logic drv, input logic val,
                             output logic samp, output logic samp_oe);
        host_en  = drv;
        host_val = val;
        sck = 1'b1;
        repeat (HALF) @(negedge clk);
        samp    = line;
        samp_oe = sda_oe;
        sck = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic handshake();
        logic s, oe;
        host_edge(1'b0, 1'b0, s, oe);
        chk(oe == 1'b1 && s == 1'b1, "R3 handshake one", {oe, s}, 3);
        zero_seen = 1'b0;
        host_edge(1'b0, 1'b0, s, oe);
        chk(oe == 1'b0 && s == 1'b0, "R4 handshake release", {oe, s}, 0);
        chk(zero_seen, "R4 handshake zero drive", zero_seen, 1);
        chk(sda_oe == 1'b0, "R5 no drive before first data edge", sda_oe, 0);
    endtask

    task automatic postamble(input string tag);
        logic s, oe;
        zero_seen = 1'b0;
        host_edge(1'b0, 1'b0, s, oe);
        chk(oe == 1'b0 && s == 1'b0, {tag, " postamble release"}, {oe, s}, 0);
        chk(zero_seen, "R11 zero before postamble release", zero_seen, 1);
        chk(busy == 1'b0, "R9 busy clear after postamble", busy, 0);
    endtask

    task automatic do_tx(input logic [BITS-1:0] b, input bit both, input bit inject);
        logic s, oe;
        @(negedge clk);
        tx_byte = b; tx_start = 1'b1; rx_req = both;
        @(negedge clk);
        tx_start = 1'b0; rx_req = 1'b0;
        chk(busy == 1'b1, "R2 busy after start", busy, 1);
        handshake();
        for (int k = 0; k < BITS; k++) begin
            if (inject && k == 3) begin
                @(negedge clk);
                tx_byte = ~b; tx_start = 1'b1; rx_req = 1'b1;
                @(negedge clk);
                tx_start = 1'b0; rx_req = 1'b0;
            end
            host_edge(1'b0, 1'b0, s, oe);
            chk(oe == 1'b1 && s == exp_bit(b, k),
                both ? "R2 send priority bit" : (inject ? "R10 bit under injected strobe" : "R5 send bit"),
                {oe, s}, {1'b1, exp_bit(b, k)});
        end
        chk(sda_oe == 1'b1 && sda_o == exp_bit(b, BITS-1), "R6 last bit held", {sda_oe, sda_o},
            {1'b1, exp_bit(b, BITS-1)});
        postamble("R6");
        if (inject) begin
            host_edge(1'b0, 1'b0, s, oe);
            chk(oe == 1'b0 && busy == 1'b0, "R10 no transfer after injected strobe",
                {oe, busy}, 0);
        end
    endtask

    task automatic do_rx(input logic [BITS-1:0] b);
        logic s, oe;
        @(negedge clk);
        rx_req = 1'b1;
        @(negedge clk);
        rx_req = 1'b0;
        chk(busy == 1'b1, "R2 busy after receive request", busy, 1);
        handshake();
        valid_cnt = 0;
        for (int k = 0; k < BITS; k++) begin
            host_edge(1'b1, exp_bit(b, k), s, oe);
            chk(oe == 1'b0, "R7 no drive during receive bit", oe, 0);
        end
        host_en = 1'b0;
        chk(valid_cnt == 1, "R7 single valid strobe", valid_cnt, 1);
        chk(last_rx == b, "R7 received byte", last_rx, b);
        postamble("R8");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R9 watchdog expired actual=busy expected=idle");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 0 && sda_oe == 0 && rx_valid == 0, "R1 reset state",
            {busy, sda_oe, rx_valid}, 0);

        do_tx(8'hA5, 1'b0, 1'b0);
        do_tx(8'h00, 1'b0, 1'b0);
        do_tx(8'hFF, 1'b0, 1'b0);
        do_rx(8'h3C);
        do_rx(8'hFF);
        do_rx(8'h00);
        do_tx(8'h96, 1'b1, 1'b0);
        do_tx(8'h5A, 1'b0, 1'b1);

        for (int i = 0; i < 24; i++) begin
            logic [BITS-1:0] b;
            b = BITS'($urandom);
            if ($urandom_range(0, 1) == 1) do_tx(b, 1'b0, 1'b0);
            else do_rx(b);
        end

        summary();
        $finish;
    end

endmodule